// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block sits next to a simple in-order pipeline and decides when the core stops in a halted debug state and when it runs again. Four kinds of event can stop the core. An outside breakpoint line tags the instruction now in execute. A level-sensitive halt request takes effect once an instruction completes. Two configurable match units can each tag an instruction address as a breakpoint or watch a data address for a value change. A restart pulse lets the core run again.

A breakpoint stops the core before the tagged instruction executes. In that same cycle the controller holds the program counter, so the counter stays on the tagged address, and it records that address. A halt request waits for a retiring instruction. A watchpoint fires only when a write to the watched address carries data that differs from the last value written there. The debug host programs the match units through plain configuration inputs. A cause vector reports every source that was active on entry.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, in_debug, halt, pc_hold and bp_entry are low, and halt_cause and halt_pc are zero.
- R2: While not halted, ext_brk high together with ex_valid raises pc_hold in that same cycle. From the next cycle halt and in_debug are high, halt_cause bit 0 is set, bp_entry is 1 and halt_pc holds that cycle's ex_pc.
- R3: An enabled unit i with unit_data_mode[i]=0 tags the instruction when ex_valid is high and ((ex_pc ^ value_i) & ~mask_i) is zero, so mask bits set to 1 are ignored. This behaves like R2 but sets halt_cause bit 2+i.
- R4: While not halted, halt_req high in a cycle with retire high halts the core from the next cycle with halt_cause bit 1 set. If no breakpoint is present, pc_hold stays low in that cycle and bp_entry and halt_pc are 0. A halt_req without retire does not halt.
- R5: An enabled unit i with unit_data_mode[i]=1 fires when mem_wr is high, mem_addr matches value_i under mask_i, and mem_wdata differs from the unit's stored value. Firing halts the core from the next cycle and sets halt_cause bit 2+i. Every matching write by such a unit updates the stored value, which resets to zero. A write of equal data does not halt.
- R6: When several sources are active in the entry cycle, a breakpoint wins: bp_entry is 1 and halt_pc is ex_pc. halt_cause records every active source.
- R7: While halted, halt, in_debug and pc_hold are high. halt_cause, halt_pc and bp_entry keep their values, and new sources have no effect.
- R8: restart while halted drops halt in the next cycle. In that cycle in_debug is still high and halt_cause, halt_pc and bp_entry are cleared. in_debug drops one cycle later unless a new source halts the core again. restart outside the halted state has no effect.
- R9: A unit with unit_en[i]=0 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_brk | input | 1 | Outside breakpoint, tags the instruction in execute |
| halt_req | input | 1 | Level-sensitive halt request |
| ex_valid | input | 1 | An instruction is entering execute |
| ex_pc | input | AW | Address of the instruction entering execute |
| retire | input | 1 | An instruction completes this cycle |
| mem_wr | input | 1 | Data write strobe |
| mem_addr | input | AW | Data write address |
| mem_wdata | input | DW | Data write value |
| restart | input | 1 | Leave debug state |
| unit_en | input | NU | Per-unit enable |
| unit_data_mode | input | NU | Per-unit mode: 0 instruction address, 1 data watch |
| unit_value | input | NU*AW | Per-unit compare address, unit i in bits [i*AW +: AW] |
| unit_mask | input | NU*AW | Per-unit ignore mask, same packing |
| in_debug | output | 1 | Debug acknowledge |
| halt | output | 1 | Pipeline stall for the whole debug state |
| pc_hold | output | 1 | Program counter update inhibit |
| halt_cause | output | NU+2 | Entry sources: bit 0 ext_brk, bit 1 halt_req, bit 2+i unit i |
| halt_pc | output | AW | Address of the breakpointed instruction |
| bp_entry | output | 1 | Entry was caused by a breakpoint |

## Verification
The assertions check on every cycle the rules that link ports over one edge. halt implies in_debug and pc_hold. The cause and address stay frozen while halted. A restart drops halt while the acknowledge lingers for one cycle. Outside breakpoints and retiring halt requests always enter with the right cause. Idle state leaves the cause vector clear. The masked address compare, the change-only watchpoint with its stored value, the priority between a breakpoint and a pending request, and the blocking of sources while halted depend on earlier history and unit settings. Only the bench's directed and random scenarios, checked against its model, can show them.

// File: rtl/dbg_halt_pkg.sv
`timescale 1ns/1ps
package dbg_halt_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALTED = 2'd1,
        ST_LEAVE  = 2'd2
    } dbg_state_e;

    localparam int CAUSE_EXT       = 0;
    localparam int CAUSE_REQ       = 1;
    localparam int CAUSE_UNIT_BASE = 2;
endpackage

// File: rtl/dbg_match_unit.sv
`timescale 1ns/1ps
module dbg_match_unit #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          data_mode,
    input  logic [AW-1:0] cmp_value,
    input  logic [AW-1:0] cmp_mask,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_pc,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          bp_hit,
    output logic          wp_hit
);
    typedef struct packed {
        logic [DW-1:0] shadow;
    } unit_regs_t;

    unit_regs_t r_d, r_q;
    logic pc_match, addr_match, watch_wr;

    always_comb begin
        r_d        = r_q;
        pc_match   = ((ex_pc ^ cmp_value) & ~cmp_mask) == '0;
        addr_match = ((wr_addr ^ cmp_value) & ~cmp_mask) == '0;
        watch_wr   = en && data_mode && wr_en && addr_match;
        bp_hit     = en && !data_mode && ex_valid && pc_match;
        wp_hit     = watch_wr && (wr_data != r_q.shadow);
        if (watch_wr) begin
            r_d.shadow = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dbg_source_merge.sv
`timescale 1ns/1ps
module dbg_source_merge
    import dbg_halt_pkg::*;
#(
    parameter int NU = 2,
    localparam int CW = NU + 2
) (
    input  logic          ext_brk,
    input  logic          ex_valid,
    input  logic          halt_req,
    input  logic          retire,
    input  logic [NU-1:0] unit_bp,
    input  logic [NU-1:0] unit_wp,
    output logic [CW-1:0] cause_now,
    output logic          bp_now
);
    always_comb begin
        cause_now            = '0;
        cause_now[CAUSE_EXT] = ext_brk && ex_valid;
        cause_now[CAUSE_REQ] = halt_req && retire;
        for (int i = 0; i < NU; i++) begin
            cause_now[CAUSE_UNIT_BASE + i] = unit_bp[i] || unit_wp[i];
        end
        bp_now = cause_now[CAUSE_EXT] || (|unit_bp);
    end
endmodule

// File: rtl/dbg_halt_fsm.sv
`timescale 1ns/1ps
module dbg_halt_fsm
    import dbg_halt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cause_now,
    input  logic          bp_now,
    input  logic [AW-1:0] ex_pc,
    input  logic          restart,
    output logic          in_debug,
    output logic          halt,
    output logic          pc_hold,
    output logic [CW-1:0] halt_cause,
    output logic [AW-1:0] halt_pc,
    output logic          bp_entry
);
    typedef struct packed {
        dbg_state_e    state;
        logic [CW-1:0] cause;
        logic [AW-1:0] pc;
        logic          bp;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic armed;

    always_comb begin
        r_d   = r_q;
        armed = (r_q.state != ST_HALTED);
        if (armed) begin
            if (cause_now != '0) begin
                r_d.state = ST_HALTED;
                r_d.cause = cause_now;
                r_d.bp    = bp_now;
                r_d.pc    = bp_now ? ex_pc : '0;
            end else begin
                r_d.state = ST_RUN;
            end
        end else if (restart) begin
            r_d.state = ST_LEAVE;
            r_d.cause = '0;
            r_d.bp    = 1'b0;
            r_d.pc    = '0;
        end
        in_debug   = (r_q.state != ST_RUN);
        halt       = (r_q.state == ST_HALTED);
        pc_hold    = halt || (armed && bp_now);
        halt_cause = r_q.cause;
        halt_pc    = r_q.pc;
        bp_entry   = r_q.bp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_RUN;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
`timescale 1ns/1ps
module dbg_halt_ctrl #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int NU = 2,
    localparam int CW = NU + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_brk,
    input  logic             halt_req,
    input  logic             ex_valid,
    input  logic [AW-1:0]    ex_pc,
    input  logic             retire,
    input  logic             mem_wr,
    input  logic [AW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_wdata,
    input  logic             restart,
    input  logic [NU-1:0]    unit_en,
    input  logic [NU-1:0]    unit_data_mode,
    input  logic [NU*AW-1:0] unit_value,
    input  logic [NU*AW-1:0] unit_mask,
    output logic             in_debug,
    output logic             halt,
    output logic             pc_hold,
    output logic [CW-1:0]    halt_cause,
    output logic [AW-1:0]    halt_pc,
    output logic             bp_entry
);
    logic [NU-1:0] unit_bp, unit_wp;
    logic [CW-1:0] cause_now;
    logic          bp_now;

    for (genvar g = 0; g < NU; g++) begin : g_unit
        dbg_match_unit #(.AW(AW), .DW(DW)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (unit_en[g]),
            .data_mode(unit_data_mode[g]),
            .cmp_value(unit_value[g*AW +: AW]),
            .cmp_mask (unit_mask[g*AW +: AW]),
            .ex_valid (ex_valid),
            .ex_pc    (ex_pc),
            .wr_en    (mem_wr),
            .wr_addr  (mem_addr),
            .wr_data  (mem_wdata),
            .bp_hit   (unit_bp[g]),
            .wp_hit   (unit_wp[g])
        );
    end

    dbg_source_merge #(.NU(NU)) u_merge (
        .ext_brk  (ext_brk),
        .ex_valid (ex_valid),
        .halt_req (halt_req),
        .retire   (retire),
        .unit_bp  (unit_bp),
        .unit_wp  (unit_wp),
        .cause_now(cause_now),
        .bp_now   (bp_now)
    );

    dbg_halt_fsm #(.AW(AW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_now (cause_now),
        .bp_now    (bp_now),
        .ex_pc     (ex_pc),
        .restart   (restart),
        .in_debug  (in_debug),
        .halt      (halt),
        .pc_hold   (pc_hold),
        .halt_cause(halt_cause),
        .halt_pc   (halt_pc),
        .bp_entry  (bp_entry)
    );
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_chk #(
    parameter int AW = 32,
    parameter int NU = 2,
    localparam int CW = NU + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_brk,
    input logic          halt_req,
    input logic          ex_valid,
    input logic [AW-1:0] ex_pc,
    input logic          retire,
    input logic          mem_wr,
    input logic          restart,
    input logic [NU-1:0] unit_en,
    input logic          in_debug,
    input logic          halt,
    input logic          pc_hold,
    input logic [CW-1:0] halt_cause,
    input logic [AW-1:0] halt_pc,
    input logic          bp_entry
);
    // R7
    halt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (in_debug && pc_hold));

    // R7
    frozen_while_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> (halt && $stable(halt_cause) && $stable(halt_pc) && $stable(bp_entry)));

    // R8
    restart_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && restart) |=> (!halt && in_debug && halt_cause == '0));

    // R2
    ext_hold_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && ex_valid && ext_brk) |-> pc_hold);

    // R2
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && ex_valid && ext_brk) |=> (halt && halt_cause[0] && bp_entry && halt_pc == $past(ex_pc)));

    // R4
    req_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && halt_req && retire) |=> (halt && halt_cause[1]));

    // R4
    req_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_debug && halt_req && !retire && !ex_valid && !mem_wr) |=> !halt);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && unit_en == '0 && !(ex_valid && ext_brk) && !(halt_req && retire)) |=> !halt);

    // R7
    cause_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (halt_cause != '0));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_debug |-> (halt_cause == '0 && !bp_entry && halt_pc == '0));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.AW(AW), .NU(NU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_brk   (ext_brk),
    .halt_req  (halt_req),
    .ex_valid  (ex_valid),
    .ex_pc     (ex_pc),
    .retire    (retire),
    .mem_wr    (mem_wr),
    .restart   (restart),
    .unit_en   (unit_en),
    .in_debug  (in_debug),
    .halt      (halt),
    .pc_hold   (pc_hold),
    .halt_cause(halt_cause),
    .halt_pc   (halt_pc),
    .bp_entry  (bp_entry)
);

// File: tb/dbg_halt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NU = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ext_brk, halt_req, ex_valid, retire, mem_wr, restart;
    logic [31:0]   ex_pc, mem_addr, mem_wdata;
    logic [1:0]    unit_en, unit_data_mode;
    logic [63:0]   unit_value, unit_mask;
    logic          in_debug, halt, pc_hold, bp_entry;
    logic [3:0]    halt_cause;
    logic [31:0]   halt_pc;

    dbg_halt_ctrl #(.AW(AW), .DW(DW), .NU(NU)) uut (
        .clk(clk), .rst_n(rst_n), .ext_brk(ext_brk), .halt_req(halt_req),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .retire(retire), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .restart(restart),
        .unit_en(unit_en), .unit_data_mode(unit_data_mode),
        .unit_value(unit_value), .unit_mask(unit_mask),
        .in_debug(in_debug), .halt(halt), .pc_hold(pc_hold),
        .halt_cause(halt_cause), .halt_pc(halt_pc), .bp_entry(bp_entry)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // bench model: 0 run, 1 halted, 2 leaving
    int          m_st = 0;
    logic [3:0]  m_cause = '0;
    logic [31:0] m_pc = '0;
    logic        m_bp = 1'b0;
    logic [31:0] m_sh [2] = '{32'd0, 32'd0};

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit amatch(logic [31:0] a, logic [31:0] v, logic [31:0] m);
        return ((a ^ v) & ~m) == 32'd0;
    endfunction

    function automatic bit unit_bp(int u);
        return unit_en[u] && !unit_data_mode[u] && ex_valid &&
               amatch(ex_pc, unit_value[u*32 +: 32], unit_mask[u*32 +: 32]);
    endfunction

    function automatic bit unit_wr(int u);
        return unit_en[u] && unit_data_mode[u] && mem_wr &&
               amatch(mem_addr, unit_value[u*32 +: 32], unit_mask[u*32 +: 32]);
    endfunction

    function automatic logic [3:0] now_cause();
        logic [3:0] c;
        c[0] = ext_brk && ex_valid;
        c[1] = halt_req && retire;
        for (int u = 0; u < 2; u++) begin
            c[2+u] = unit_bp(u) || (unit_wr(u) && mem_wdata != m_sh[u]);
        end
        return c;
    endfunction

    function automatic bit now_bp();
        return (ext_brk && ex_valid) || unit_bp(0) || unit_bp(1);
    endfunction

    task automatic cycle();
        logic [3:0] c;
        bit b;
        bit w0, w1;
        #1;
        chk("R7 halt", halt, m_st == 1);
        chk("R8 in_debug", in_debug, m_st != 0);
        chk("R2 pc_hold", pc_hold, (m_st == 1) || (m_st != 1 && now_bp()));
        chk("R6 halt_cause", halt_cause, m_cause);
        chk("R6 halt_pc", halt_pc, m_pc);
        chk("R6 bp_entry", bp_entry, m_bp);
        c = now_cause();
        b = now_bp();
        w0 = unit_wr(0);
        w1 = unit_wr(1);
        @(posedge clk);
        if (m_st != 1) begin
            if (c != 0) begin
                m_st = 1; m_cause = c; m_bp = b; m_pc = b ? ex_pc : 32'd0;
            end else begin
                m_st = 0;
            end
        end else if (restart) begin
            m_st = 2; m_cause = '0; m_bp = 1'b0; m_pc = '0;
        end
        if (w0) m_sh[0] = mem_wdata;
        if (w1) m_sh[1] = mem_wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        ext_brk = 0; halt_req = 0; ex_valid = 0; retire = 0; mem_wr = 0; restart = 0;
    endtask

    task automatic leave_debug();
        idle();
        restart = 1;
        cycle();
        restart = 0;
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        ex_pc = '0; mem_addr = '0; mem_wdata = '0;
        unit_en = '0; unit_data_mode = '0; unit_value = '0; unit_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 in_debug", in_debug, 0);
        chk("R1 halt", halt, 0);
        chk("R1 pc_hold", pc_hold, 0);
        chk("R1 halt_cause", halt_cause, 0);
        chk("R1 halt_pc", halt_pc, 0);
        chk("R1 bp_entry", bp_entry, 0);

        // R4: request waits for retire
        halt_req = 1;
        repeat (3) cycle();
        chk("R4 no halt without retire", halt, 0);
        retire = 1;
        #1 chk("R4 no pc_hold on request", pc_hold, 0);
        cycle();
        chk("R4 halt", halt, 1);
        chk("R4 cause", halt_cause, 4'b0010);
        chk("R4 bp_entry", bp_entry, 0);
        idle();
        restart = 1;
        cycle();
        chk("R8 halt dropped", halt, 0);
        chk("R8 ack lingers", in_debug, 1);
        chk("R8 cause cleared", halt_cause, 0);
        restart = 0;
        cycle();
        chk("R8 ack dropped", in_debug, 0);
        restart = 1;
        cycle();
        chk("R8 restart ignored when running", in_debug, 0);
        restart = 0;

        // R3: masked instruction address compare on unit 0
        unit_en = 2'b01; unit_data_mode = 2'b00;
        unit_value[31:0] = 32'h100; unit_mask[31:0] = 32'hF;
        ex_valid = 1; ex_pc = 32'h10C;
        #1 chk("R3 pc_hold same cycle", pc_hold, 1);
        cycle();
        chk("R3 cause", halt_cause, 4'b0100);
        chk("R3 halt_pc", halt_pc, 32'h10C);
        // R7: sources ignored while halted
        ext_brk = 1; ex_pc = 32'h44; halt_req = 1; retire = 1;
        cycle();
        chk("R7 cause held", halt_cause, 4'b0100);
        chk("R7 halt_pc held", halt_pc, 32'h10C);
        leave_debug();
        ex_valid = 1; ex_pc = 32'h110;
        cycle();
        chk("R3 unmasked bit differs", halt, 0);
        idle();

        // R6: breakpoint and request together
        ext_brk = 1; ex_valid = 1; ex_pc = 32'h40; halt_req = 1; retire = 1;
        cycle();
        chk("R6 cause all", halt_cause, 4'b0011);
        chk("R6 bp wins", bp_entry, 1);
        chk("R6 halt_pc", halt_pc, 32'h40);
        leave_debug();

        // R5: change-only watchpoint on unit 1
        unit_en = 2'b10; unit_data_mode = 2'b10;
        unit_value[63:32] = 32'h20; unit_mask[63:32] = 32'h0;
        mem_wr = 1; mem_addr = 32'h20; mem_wdata = 32'd0;
        cycle();
        chk("R5 equal write no halt", halt, 0);
        mem_wdata = 32'd7;
        #1 chk("R5 no pc_hold on watch", pc_hold, 0);
        cycle();
        chk("R5 cause", halt_cause, 4'b1000);
        chk("R5 bp_entry", bp_entry, 0);
        leave_debug();
        mem_wr = 1; mem_addr = 32'h20; mem_wdata = 32'd7;
        cycle();
        chk("R5 repeat value no halt", halt, 0);
        mem_addr = 32'h24; mem_wdata = 32'd9;
        cycle();
        chk("R5 other address no halt", halt, 0);
        idle();

        // R9: disabled unit
        unit_en = 2'b00; unit_data_mode = 2'b00;
        unit_value[31:0] = 32'h100; unit_mask[31:0] = 32'h0;
        ex_valid = 1; ex_pc = 32'h100;
        cycle();
        chk("R9 disabled no halt", halt, 0);
        idle();
        cycle();

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            if (n % 200 == 0) begin
                unit_en = 2'($urandom);
                unit_data_mode = 2'($urandom);
                for (int u = 0; u < 2; u++) begin
                    unit_value[u*32 +: 32] = ($urandom % 16) << 2;
                    case ($urandom % 3)
                        0: unit_mask[u*32 +: 32] = 32'h0;
                        1: unit_mask[u*32 +: 32] = 32'h4;
                        default: unit_mask[u*32 +: 32] = 32'hC;
                    endcase
                end
            end
            ex_valid  = ($urandom % 2) == 0;
            ex_pc     = ($urandom % 16) << 2;
            ext_brk   = ($urandom % 16) == 0;
            halt_req  = ($urandom % 8) == 0;
            retire    = ($urandom % 2) == 0;
            mem_wr    = ($urandom % 10) < 3;
            mem_addr  = ($urandom % 8) << 2;
            mem_wdata = $urandom % 3;
            restart   = ($urandom % 4) == 0;
            cycle();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule